// File: doc/BRIEF.md
# Dot Clock PLL Selection Sequencer

This block turns a requested pixel clock, given in kHz, into a programmed PLL configuration. It accepts one request at a time over a valid/ready port. A request is taken only while the block is idle. The requester must hold `req_valid` and `req_khz` steady until `req_ready` is seen high at a rising edge. While a request is being served, `req_ready` stays low, and that low level is the back-pressure.

After accepting a request, the block walks a constant table of 16 supported frequencies, one entry per clock cycle, and keeps the entry closest to the request. The configuration word of that entry is masked. If the PLL already reports lock with that same word, the block finishes at once. Otherwise it writes the word, holds the PLL in reset for a fixed settling time, and then samples the lock flag up to a fixed number of times. It releases the reset in every case and reports completion.

Top module: `dotclk_pll_seq`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low, and `busy` is high from the cycle after acceptance until the sequence completes.
- R2: The selected table entry is the one with the smallest absolute difference between its kHz value and `req_khz`. Requests below the lowest entry or above the highest entry select the end entry nearest to them.
- R3: When two entries are equally close, the entry earlier in the table (lower index) is kept. Only a strictly smaller difference replaces the current choice.
- R4: The configuration word driven on `pll_cfg` is the table word ANDed with `CFG_MASK` (default 0x00017FFF). For example, table word 0x8009A0C1 is driven as 0x000120C1.
- R5: If `pll_lock` is high and `pll_cfg` already equals the new masked word when the scan ends, `done` pulses ENTRIES+1 cycles after the accepting edge. In that case `pll_cfg`, `pll_rst`, `pll_bypass` and `pll_halfpix` do not change.
- R6: Otherwise, on the cycle after the scan ends, the block does all of the following on the same edge: loads `pll_cfg` with the new word, sets `pll_rst`, and clears `pll_bypass` and `pll_halfpix`.
- R7: The lock flag is first sampled WAIT_US×CLK_MHZ cycles after programming. When lock is already present at that first sample, `done` arrives WAIT_US×CLK_MHZ+ENTRIES+2 cycles after the accepting edge.
- R8: If lock is not seen in POLL_LIMIT consecutive samples, `timeout` is raised together with `done`, ENTRIES+1+WAIT_US×CLK_MHZ+POLL_LIMIT cycles after the accepting edge.
- R9: `pll_rst` is low in the cycle `done` is high, whether lock was seen or the sample limit was reached.
- R10: `done` is high for exactly one cycle. `timeout` holds its value until the next request is accepted, which clears it.
- R11: After reset the outputs are: `pll_cfg`=0, `pll_rst`=0, `pll_bypass`=1, `pll_halfpix`=1, `done`=0, `timeout`=0, `busy`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_khz | input | FREQ_W (20) | Requested pixel clock in kHz |
| pll_lock | input | 1 | PLL lock flag |
| pll_cfg | output | CFG_W (32) | PLL configuration word |
| pll_rst | output | 1 | PLL reset control |
| pll_bypass | output | 1 | PLL bypass control |
| pll_halfpix | output | 1 | PLL half-pixel control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last sequence ended without lock |

## Verification
The latency of each result is counted in rising edges after the edge that accepts the request:
- A skipped reprogram completes after ENTRIES+1 = 17 edges.
- A locked reprogram completes after WAIT_US×CLK_MHZ+18 edges.
- A run that hits the sample limit completes after WAIT_US×CLK_MHZ+POLL_LIMIT+17 edges.

The bench counts edges from acceptance and samples every output on the falling edge. It compares the count at the first high `done` against these figures. On that same sample it reads `pll_cfg`, `pll_rst`, `timeout` and the two control bits. It then checks one cycle later that `done` has dropped.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int ENTRIES  = 16;
  localparam int ROM_IDX_W = $clog2(ENTRIES);
  localparam int KHZ_W    = 20;
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic [KHZ_W-1:0]  khz;
    logic [WORD_W-1:0] word;
  } dpll_entry_t;

  // Supported dot clocks, ascending in kHz, with raw configuration words.
  function automatic dpll_entry_t dpll_entry(input logic [ROM_IDX_W-1:0] i);
    dpll_entry_t e;
    case (i)
      4'd0:    e = '{khz: 20'd25175,  word: 32'h0000_215D};
      4'd1:    e = '{khz: 20'd27000,  word: 32'h0000_1087};
      4'd2:    e = '{khz: 20'd31500,  word: 32'h0000_3147};
      4'd3:    e = '{khz: 20'd36000,  word: 32'h0000_0057};
      4'd4:    e = '{khz: 20'd40000,  word: 32'h0000_0045};
      4'd5:    e = '{khz: 20'd49500,  word: 32'h0000_3207};
      4'd6:    e = '{khz: 20'd50000,  word: 32'h0000_2187};
      4'd7:    e = '{khz: 20'd56250,  word: 32'h0000_4286};
      4'd8:    e = '{khz: 20'd65000,  word: 32'h0000_4214};
      4'd9:    e = '{khz: 20'd74250,  word: 32'h0000_31E4};
      4'd10:   e = '{khz: 20'd78750,  word: 32'h0000_4284};
      4'd11:   e = '{khz: 20'd94500,  word: 32'h0000_6363};
      4'd12:   e = '{khz: 20'd108000, word: 32'h0000_1081};
      4'd13:   e = '{khz: 20'd135000, word: 32'h0000_41B1};
      4'd14:   e = '{khz: 20'd157500, word: 32'h0000_62D1};
      default: e = '{khz: 20'd162000, word: 32'h8009_A0C1};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/dpll_rom.sv
module dpll_rom
  import dpll_pkg::*;
(
  input  logic [ROM_IDX_W-1:0] idx,
  output logic [KHZ_W-1:0]     khz,
  output logic [WORD_W-1:0]    word
);
  dpll_entry_t ent;

  always_comb begin
    ent  = dpll_entry(idx);
    khz  = ent.khz;
    word = ent.word;
  end
endmodule

// File: rtl/dpll_scan.sv
module dpll_scan
  import dpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KHZ_W-1:0]  target_khz,
  output logic              scan_done,
  output logic [WORD_W-1:0] best_word
);
  localparam logic [ROM_IDX_W-1:0] LAST_IDX = ROM_IDX_W'(ENTRIES - 1);

  logic                 active;
  logic [ROM_IDX_W-1:0] idx;
  logic [KHZ_W-1:0]     ent_khz;
  logic [WORD_W-1:0]    ent_word;
  logic [KHZ_W-1:0]     diff;
  logic [KHZ_W-1:0]     min_diff;

  dpll_rom u_rom (
    .idx  (idx),
    .khz  (ent_khz),
    .word (ent_word)
  );

  always_comb begin
    if (ent_khz >= target_khz) diff = ent_khz - target_khz;
    else                       diff = target_khz - ent_khz;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      min_diff  <= '0;
      best_word <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        // first entry always seeds; later ones must be strictly closer
        if (idx == '0 || diff < min_diff) begin
          min_diff  <= diff;
          best_word <= ent_word;
        end
        if (idx == LAST_IDX) begin
          active    <= 1'b0;
          scan_done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dpll_counter.sv
module dpll_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dotclk_pll_seq.sv
module dotclk_pll_seq
  import dpll_pkg::*;
#(
  parameter int               FREQ_W     = KHZ_W,
  parameter int               CFG_W      = WORD_W,
  parameter int               CLK_MHZ    = 125,
  parameter int               WAIT_US    = 100,
  parameter int               POLL_LIMIT = 1000,
  parameter logic [CFG_W-1:0] CFG_MASK   = 32'h0001_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_khz,
  input  logic              pll_lock,
  output logic [CFG_W-1:0]  pll_cfg,
  output logic              pll_rst,
  output logic              pll_bypass,
  output logic              pll_halfpix,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CNT_MAX  = (WAIT_CYC > POLL_LIMIT) ? WAIT_CYC : POLL_LIMIT;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_LIMIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT, ST_POLL} seq_state_t;

  seq_state_t        state;
  logic [KHZ_W-1:0]  target_q;
  logic              accept;
  logic              scan_done;
  logic [WORD_W-1:0] best_word;
  logic [CFG_W-1:0]  sel_word;
  logic              cnt_clr;
  logic              cnt_en;
  logic [CNT_W-1:0]  cnt;
  logic              wait_end;
  logic              poll_end;

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign sel_word  = CFG_W'(best_word) & CFG_MASK;
  assign wait_end  = (state == ST_WAIT) && (cnt == WAIT_LAST);
  assign poll_end  = (state == ST_POLL) && (pll_lock || cnt == POLL_LAST);
  assign cnt_clr   = (state == ST_SCAN) || wait_end;
  assign cnt_en    = (state == ST_WAIT) || (state == ST_POLL);

  dpll_scan u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .target_khz (target_q),
    .scan_done  (scan_done),
    .best_word  (best_word)
  );

  dpll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      target_q    <= '0;
      pll_cfg     <= '0;
      pll_rst     <= 1'b0;
      pll_bypass  <= 1'b1;
      pll_halfpix <= 1'b1;
      done        <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            target_q <= KHZ_W'(req_khz);
            timeout  <= 1'b0;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_done) begin
            if (pll_lock && pll_cfg == sel_word) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              pll_cfg     <= sel_word;
              pll_rst     <= 1'b1;
              pll_bypass  <= 1'b0;
              pll_halfpix <= 1'b0;
              state       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (wait_end) state <= ST_POLL;
        end
        ST_POLL: begin
          if (poll_end) begin
            pll_rst <= 1'b0;
            done    <= 1'b1;
            timeout <= !pll_lock;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dotclk_pll_seq_chk.sv
module dotclk_pll_seq_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CFG_W-1:0] pll_cfg,
  input logic             pll_rst,
  input logic             pll_bypass,
  input logic             pll_halfpix,
  input logic             busy,
  input logic             done,
  input logic             timeout
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R6
  prog_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst) |-> (!pll_bypass && !pll_halfpix && busy));

  // R6
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg) |-> (busy && pll_rst));

  // R5
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> busy);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pll_rst);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  // R10
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> $stable(timeout));
endmodule

bind dotclk_pll_seq dotclk_pll_seq_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/sim_dotclk_pll_seq.sv
module sim_dotclk_pll_seq;
  localparam int NENT     = 16;
  localparam int WCYC     = 125 * 100;
  localparam int PLIM     = 1000;
  localparam int LAT_SKIP = NENT + 1;
  localparam int LAT_PROG = WCYC + NENT + 2;
  localparam int LAT_TO   = NENT + 1 + WCYC + PLIM;
  localparam int LOCK_DLY = 50;
  localparam int NVEC     = 7;

  localparam logic [19:0] V_KHZ [NVEC] = '{20'd65100, 20'd65000, 20'd49750,
    20'd1000, 20'd999999, 20'd30000, 20'd30000};
  localparam logic [31:0] V_CFG [NVEC] = '{32'h4214, 32'h4214, 32'h3207,
    32'h215D, 32'h120C1, 32'h3147, 32'h3147};
  localparam bit V_SKIP [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_khz = '0;
  logic        pll_lock;
  logic [31:0] pll_cfg;
  logic        pll_rst, pll_bypass, pll_halfpix, busy, done, timeout;

  int checks = 0;
  int fails  = 0;
  bit lock_en = 1'b1;
  int lock_cnt = 0;
  bit rst_prev = 1'b0;
  int rst_rises = 0;

  always #4 clk = ~clk;

  dotclk_pll_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_khz(req_khz), .pll_lock(pll_lock), .pll_cfg(pll_cfg),
    .pll_rst(pll_rst), .pll_bypass(pll_bypass), .pll_halfpix(pll_halfpix),
    .busy(busy), .done(done), .timeout(timeout)
  );

  // PLL model: lock drops under reset and returns LOCK_DLY cycles later
  always @(posedge clk) begin
    if (!rst_n) begin
      pll_lock <= 1'b0;
      lock_cnt <= 0;
      rst_prev <= 1'b0;
    end else begin
      rst_prev <= pll_rst;
      if (pll_rst && !rst_prev) rst_rises <= rst_rises + 1;
      if (pll_rst) begin
        if (lock_cnt < LOCK_DLY) lock_cnt <= lock_cnt + 1;
        pll_lock <= lock_en && (lock_cnt >= LOCK_DLY);
      end else begin
        lock_cnt <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [19:0] khz, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_khz   = khz;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    chk(busy && !req_ready, "R1 busy after accept", {busy, req_ready}, 2'b10);
    while (!done) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic chk_pulse_end();
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int rises_before;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pll_cfg == 0, "R11 cfg", pll_cfg, 0);
    chk({pll_rst, pll_bypass, pll_halfpix} == 3'b011, "R11 ctrl bits",
        {pll_rst, pll_bypass, pll_halfpix}, 3'b011);
    chk({done, timeout, busy, req_ready} == 4'b0001, "R11 status",
        {done, timeout, busy, req_ready}, 4'b0001);

    // vector table: R2 nearest, R3 tie, R4 mask, R5 skip, R6/R7 program
    for (int v = 0; v < NVEC; v++) begin
      rises_before = rst_rises;
      run_req(V_KHZ[v], lat);
      chk(pll_cfg == V_CFG[v], "R2/R3/R4 selected word", pll_cfg, V_CFG[v]);
      if (V_SKIP[v]) begin
        chk(lat == LAT_SKIP, "R5 skip latency", lat, LAT_SKIP);
        chk(rst_rises == rises_before, "R5 no reset toggle", rst_rises, rises_before);
      end else begin
        chk(lat == LAT_PROG, "R7 programmed latency", lat, LAT_PROG);
        chk(rst_rises == rises_before + 1, "R6 reset pulsed", rst_rises, rises_before + 1);
        chk(!pll_bypass && !pll_halfpix, "R6 bypass halfpix cleared",
            {pll_bypass, pll_halfpix}, 0);
      end
      chk(!pll_rst, "R9 reset released", pll_rst, 0);
      chk(!timeout, "R8 no timeout when locked", timeout, 0);
      chk_pulse_end();
    end

    // R8 sample limit reached without lock
    lock_en = 1'b0;
    rises_before = rst_rises;
    run_req(20'd40000, lat);
    chk(lat == LAT_TO, "R8 timeout latency", lat, LAT_TO);
    chk(timeout, "R8 timeout raised", timeout, 1);
    chk(!pll_rst, "R9 reset released on timeout", pll_rst, 0);
    chk(pll_cfg == 32'h45, "R2 exact match", pll_cfg, 32'h45);
    chk_pulse_end();
    repeat (5) @(negedge clk);
    chk(timeout, "R10 timeout held", timeout, 1);

    // R5 same word but not locked must reprogram; R10 timeout cleared
    lock_en = 1'b1;
    rises_before = rst_rises;
    run_req(20'd40000, lat);
    chk(rst_rises == rises_before + 1, "R5 reprogram when unlocked",
        rst_rises, rises_before + 1);
    chk(lat == LAT_PROG, "R7 latency after relock", lat, LAT_PROG);
    chk(!timeout, "R10 timeout cleared", timeout, 0);
    chk(!busy && req_ready, "R1 idle at done", {busy, req_ready}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule